// File: doc/BRIEF.md
# Loop Criticality Marker

This block watches the decoded instruction stream and labels each instruction as critical or not for the purpose of scheduling its consumers' wakeup. Loads are labelled critical outright. The instructions that feed load and store addresses are learned: when a load or store is decoded, the block finds out which instruction last wrote its address register and remembers that instruction's PC. The next time that PC is decoded, usually on the next pass of a loop, it is labelled critical as well.

Two tables hold the learned state. A writer table keeps, for every architectural register, the PC of the most recent instruction that wrote it. A slice table is direct-mapped and tag-checked. It keeps the PCs already known to belong to an address slice. A non-memory instruction that hits in the slice table also traces its own address source, so the marked slice grows one producer further back on each loop pass. One instruction is accepted per cycle, and its label appears on the output one cycle later.

Top module: `crit_detector`

## Requirements
- R1: For each cycle with `in_vld_i` high at a rising edge, `crit_vld_o` is high for exactly the following cycle. In a cycle after an edge with `in_vld_i` low, `crit_vld_o` is low. `crit_o` is never high while `crit_vld_o` is low.
- R2: An instruction of class LOAD (`in_cls_i` = 1) is reported critical every time, including its first occurrence.
- R3: An instruction of class STORE (2) or BRANCH (3) is never reported critical, even when its PC is present in the slice table.
- R4: When a LOAD is accepted and the writer table holds a writer for its address source register `in_addr_src_i`, that writer's PC enters the slice table. A later ALU-class (0) instruction at that PC is reported critical.
- R5: A STORE's address source register is traced in the same way, so the writer of a store address becomes critical on its next occurrence.
- R6: An ALU-class instruction that hits in the slice table is reported critical. Its own address source writer is then inserted, so the slice extends backward by one producer per occurrence.
- R7: An ALU-class instruction whose PC is not in the slice table is reported not critical.
- R8: The writer table is updated with an instruction's PC for `in_dst_i` (when `in_dst_vld_i` is high) only after that instruction's source lookup. An instruction that reads and writes the same register therefore traces the previous writer, not itself.
- R9: The slice table is direct-mapped. It is indexed by PC bits [8:2] when there are 128 entries, and a full tag is compared. A PC that shares an index with a stored PC but differs in tag misses. An insertion overwrites the stored PC, which then misses.
- R10: When an instruction's lookup and the insertion it triggers target the same slice entry in one cycle, the label uses the contents from before the insertion.
- R11: Reset drops `crit_vld_o` and empties both tables. Earlier learned producers are not critical afterwards, and a load issued after reset inserts nothing for writers seen before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_vld_i | input | 1 | A decoded instruction is presented this cycle |
| in_pc_i | input | PC_W | Instruction PC |
| in_cls_i | input | 2 | Class: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| in_addr_src_i | input | log2(NUM_REGS) | Address source register |
| in_dst_i | input | log2(NUM_REGS) | Destination register |
| in_dst_vld_i | input | 1 | The instruction writes `in_dst_i` |
| crit_vld_o | output | 1 | Label for the previous cycle's instruction is valid |
| crit_o | output | 1 | That instruction is critical |

## Verification
A corrupted writer-table entry does not change the label of the instruction being decoded. It appears as a wrong producer becoming critical, or a right one staying non-critical, on the next occurrence of that producer's PC, so the stimulus always replays the producer after the consumer. A stale or mis-tagged slice entry appears on the very next lookup at that index, which is why aliasing PCs that differ only above bit 8 are decoded back to back. The read-before-write ordering is exposed only through the producer chosen for insertion, and the bench observes it one loop pass later.

// File: rtl/crit_det_pkg.sv
package crit_det_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_BRANCH = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic crit_vld;
        logic crit;
    } out_state_t;

endpackage

// File: rtl/slice_table.sv
module slice_table #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 128
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PC_W-1:0] look_pc_i,
    output logic            hit_o,
    input  logic            ins_vld_i,
    input  logic [PC_W-1:0] ins_pc_i
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic [ENTRIES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0]   tag_d [ENTRIES];
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    logic [IDX_W-1:0] look_idx, ins_idx;
    logic [TAG_W-1:0] look_tag, ins_tag;

    // index from word bits above the byte offset; the offset bits stay in the tag
    assign look_idx = look_pc_i[IDX_W+1:2];
    assign look_tag = {look_pc_i[PC_W-1:IDX_W+2], look_pc_i[1:0]};
    assign ins_idx  = ins_pc_i[IDX_W+1:2];
    assign ins_tag  = {ins_pc_i[PC_W-1:IDX_W+2], ins_pc_i[1:0]};

    // lookup reads registered contents: a same-cycle insertion is not visible
    assign hit_o = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        if (ins_vld_i) begin
            vld_d[ins_idx] = 1'b1;
            tag_d[ins_idx] = ins_tag;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
        tag_q <= tag_d;
    end

endmodule

// File: rtl/writer_table.sv
module writer_table #(
    parameter int PC_W     = 32,
    parameter int NUM_REGS = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [$clog2(NUM_REGS)-1:0] rd_reg_i,
    output logic                        rd_vld_o,
    output logic [PC_W-1:0]             rd_pc_o,
    input  logic                        wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0] wr_reg_i,
    input  logic [PC_W-1:0]             wr_pc_i
);
    logic [NUM_REGS-1:0] vld_d, vld_q;
    logic [PC_W-1:0]     pc_d [NUM_REGS];
    logic [PC_W-1:0]     pc_q [NUM_REGS];

    // read of old state; the write lands at the edge, after the read
    assign rd_vld_o = vld_q[rd_reg_i];
    assign rd_pc_o  = pc_q[rd_reg_i];

    always_comb begin
        vld_d = vld_q;
        pc_d  = pc_q;
        if (wr_en_i) begin
            vld_d[wr_reg_i] = 1'b1;
            pc_d[wr_reg_i]  = wr_pc_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
        pc_q <= pc_d;
    end

endmodule

// File: rtl/crit_detector.sv
module crit_detector
    import crit_det_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int NUM_REGS    = 32,
    parameter int IST_ENTRIES = 128
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        in_vld_i,
    input  logic [PC_W-1:0]             in_pc_i,
    input  logic [1:0]                  in_cls_i,
    input  logic [$clog2(NUM_REGS)-1:0] in_addr_src_i,
    input  logic [$clog2(NUM_REGS)-1:0] in_dst_i,
    input  logic                        in_dst_vld_i,
    output logic                        crit_vld_o,
    output logic                        crit_o
);
    op_cls_e         cls;
    logic            slice_hit;
    logic            wr_known;
    logic [PC_W-1:0] wr_pc;
    logic            trace_en;
    logic            ins_vld;
    logic            rdt_wr;
    out_state_t      st_d, st_q;

    assign cls = op_cls_e'(in_cls_i);

    slice_table #(
        .PC_W    (PC_W),
        .ENTRIES (IST_ENTRIES)
    ) u_slice (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .look_pc_i (in_pc_i),
        .hit_o     (slice_hit),
        .ins_vld_i (ins_vld),
        .ins_pc_i  (wr_pc)
    );

    writer_table #(
        .PC_W     (PC_W),
        .NUM_REGS (NUM_REGS)
    ) u_writers (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_reg_i (in_addr_src_i),
        .rd_vld_o (wr_known),
        .rd_pc_o  (wr_pc),
        .wr_en_i  (rdt_wr),
        .wr_reg_i (in_dst_i),
        .wr_pc_i  (in_pc_i)
    );

    always_comb begin
        trace_en = 1'b0;
        st_d     = '0;
        rdt_wr   = in_vld_i && in_dst_vld_i;
        if (in_vld_i) begin
            st_d.crit_vld = 1'b1;
            unique case (cls)
                CLS_LOAD: begin
                    st_d.crit = 1'b1;
                    trace_en  = 1'b1;
                end
                CLS_STORE: begin
                    st_d.crit = 1'b0;
                    trace_en  = 1'b1;
                end
                CLS_ALU: begin
                    st_d.crit = slice_hit;
                    trace_en  = slice_hit;
                end
                default: begin
                    st_d.crit = 1'b0;
                    trace_en  = 1'b0;
                end
            endcase
        end
        ins_vld = trace_en && wr_known;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crit_vld_o = st_q.crit_vld;
    assign crit_o     = st_q.crit;

endmodule

// File: rtl/crit_detector_chk.sv
module crit_detector_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       in_vld_i,
    input logic [1:0] in_cls_i,
    input logic       crit_vld_o,
    input logic       crit_o
);
    // R1
    valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_vld_i |=> crit_vld_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_vld_i |=> !crit_vld_o);

    // R1
    crit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crit_o |-> crit_vld_o);

    // R2
    load_critical_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && in_cls_i == crit_det_pkg::CLS_LOAD) |=> crit_o);

    // R3
    store_branch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && (in_cls_i == crit_det_pkg::CLS_STORE ||
                      in_cls_i == crit_det_pkg::CLS_BRANCH)) |=> !crit_o);

endmodule

bind crit_detector crit_detector_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_vld_i   (in_vld_i),
    .in_cls_i   (in_cls_i),
    .crit_vld_o (crit_vld_o),
    .crit_o     (crit_o)
);

// File: tb/crit_detector_tb.sv
module crit_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_pc = '0;
    logic [1:0]  in_cls = '0;
    logic [4:0]  in_src = '0;
    logic [4:0]  in_dst = '0;
    logic        in_dv = 1'b0;
    logic        crit_vld;
    logic        crit;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    crit_detector u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .in_vld_i      (in_vld),
        .in_pc_i       (in_pc),
        .in_cls_i      (in_cls),
        .in_addr_src_i (in_src),
        .in_dst_i      (in_dst),
        .in_dst_vld_i  (in_dv),
        .crit_vld_o    (crit_vld),
        .crit_o        (crit)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [1:0]  cls;
        logic [4:0]  src;
        logic [4:0]  dst;
        logic        dv;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    // class: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH
    localparam vec_t VECS [NV] = '{
        '{32'h100, 2'd0, 5'd1,  5'd3,  1'b1, 1'b0, 8'd7},  // R7 first sight
        '{32'h104, 2'd1, 5'd3,  5'd4,  1'b1, 1'b1, 8'd2},  // R2 load, learns 0x100
        '{32'h100, 2'd0, 5'd1,  5'd3,  1'b1, 1'b1, 8'd4},  // R4 producer now critical
        '{32'h108, 2'd0, 5'd5,  5'd1,  1'b1, 1'b0, 8'd7},
        '{32'h100, 2'd0, 5'd1,  5'd3,  1'b1, 1'b1, 8'd6},  // R6 hit traces 0x108
        '{32'h108, 2'd0, 5'd5,  5'd1,  1'b1, 1'b1, 8'd6},  // R6 one level further
        '{32'h10C, 2'd0, 5'd2,  5'd6,  1'b1, 1'b0, 8'd7},
        '{32'h110, 2'd2, 5'd6,  5'd0,  1'b0, 1'b0, 8'd3},  // R3 store, learns 0x10C
        '{32'h10C, 2'd0, 5'd2,  5'd6,  1'b1, 1'b1, 8'd5},  // R5
        '{32'h118, 2'd3, 5'd7,  5'd8,  1'b1, 1'b0, 8'd3},  // R3 branch
        '{32'h11C, 2'd1, 5'd8,  5'd20, 1'b1, 1'b1, 8'd2},  // R2 learns branch 0x118
        '{32'h118, 2'd3, 5'd7,  5'd8,  1'b1, 1'b0, 8'd3},  // R3 in table, still quiet
        '{32'h120, 2'd0, 5'd7,  5'd21, 1'b1, 1'b0, 8'd7},
        '{32'h128, 2'd0, 5'd10, 5'd9,  1'b1, 1'b0, 8'd7},
        '{32'h12C, 2'd1, 5'd9,  5'd22, 1'b1, 1'b1, 8'd2},  // learns 0x128
        '{32'h130, 2'd0, 5'd11, 5'd9,  1'b1, 1'b0, 8'd8},  // R8 newer writer of r9
        '{32'h128, 2'd0, 5'd9,  5'd9,  1'b1, 1'b1, 8'd8},  // R8 reads r9 and writes r9
        '{32'h130, 2'd0, 5'd11, 5'd9,  1'b1, 1'b1, 8'd8},  // R8 older writer was traced
        '{32'h328, 2'd0, 5'd23, 5'd12, 1'b1, 1'b0, 8'd9},  // R9 alias of 0x128 misses
        '{32'h134, 2'd1, 5'd12, 5'd24, 1'b1, 1'b1, 8'd2},  // learns 0x328 over 0x128
        '{32'h328, 2'd0, 5'd23, 5'd12, 1'b1, 1'b1, 8'd9},  // R9
        '{32'h128, 2'd0, 5'd13, 5'd14, 1'b1, 1'b0, 8'd9},  // R9 displaced
        '{32'h30C, 2'd0, 5'd15, 5'd2,  1'b1, 1'b0, 8'd9},
        '{32'h10C, 2'd0, 5'd2,  5'd6,  1'b1, 1'b1, 8'd10}, // R10 old contents
        '{32'h10C, 2'd0, 5'd2,  5'd6,  1'b1, 1'b0, 8'd10}, // R10 now overwritten
        '{32'h30C, 2'd0, 5'd15, 5'd2,  1'b1, 1'b1, 8'd10}  // R10
    };

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] pc, input logic [1:0] cls,
                         input logic [4:0] src, input logic [4:0] dst, input logic dv);
        @(negedge clk);
        in_vld = 1'b1;
        in_pc  = pc;
        in_cls = cls;
        in_src = src;
        in_dst = dst;
        in_dv  = dv;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R11 reset valid", crit_vld, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].pc, VECS[i].cls, VECS[i].src, VECS[i].dst, VECS[i].dv);
            check("R1 valid", crit_vld, 1'b1);
            if (crit !== VECS[i].exp) begin
                $display("FAIL R%0d vector %0d pc %h: got %0b expected %0b",
                         VECS[i].req, i, VECS[i].pc, crit, VECS[i].exp);
                fails++;
            end
            checks++;
        end

        // R1 idle cycle gives no label
        idle();
        check("R1 idle valid", crit_vld, 1'b0);
        check("R1 idle crit", crit, 1'b0);

        // R11 reset mid-run empties both tables
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R11 valid in reset", crit_vld, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(32'h100, 2'd0, 5'd1, 5'd3, 1'b0);
        check("R11 learned slice cleared", crit, 1'b0);
        issue(32'h104, 2'd1, 5'd3, 5'd4, 1'b0);
        check("R2 load after reset", crit, 1'b1);
        issue(32'h100, 2'd0, 5'd1, 5'd3, 1'b0);
        check("R11 writers cleared", crit, 1'b0);
        idle();

        summary();
        $finish;
    end

endmodule